// File: doc/BRIEF.md
# Multi-Pass Neuron Weighted-Sum Datapath

This block forms the pre-activation value of one neuron of a fully connected layer. A fixed number of multiplier lanes is reused over as many passes as the neuron needs. In each pass every lane multiplies one input word by one weight. The lane takes that weight from its own small weight store, which is read as a ring. The lane products are added together. The first pass of a neuron adds the neuron's bias to that total. Every later pass adds the running accumulator instead. When the last pass arrives, the total is shifted left by the layer's power-of-two scale, which undoes an offline down-scaling of weights and biases. The result is clamped to the fractional range and presented with a one-cycle valid strobe.

Inputs and weights are signed fractions of N+1 bits. Each product is truncated to an L+1 bit fraction. The sum path carries a configurable number of pipeline registers, and the valid and control bits travel beside the data. A small accumulator state machine tracks whether a neuron is in progress. In state ACC_IDLE it waits for a pass marked first. The transition start goes to ACC_RUN when that first pass is not also the last. The transition single_pass stays in ACC_IDLE and emits a result. In ACC_RUN the transition middle_pass stays in ACC_RUN. The transition finish goes back to ACC_IDLE on the last pass. The transition restart reloads the bias when a new first pass arrives while ACC_RUN is active.

Top module: `neuron_mac_path`

## Requirements
- R1: Each active lane yields floor(x*w / 2^(2N-L)) as an L+1 bit signed fraction. The one product that does not fit, (-1)*(-1), is clamped to 2^L-1.
- R2: On a pass with in_first set, the sum starts from in_bias*2^(L-N). On later passes of the same neuron, the lane products are added to the running accumulator.
- R3: The accumulator is wide enough for the sum of every possible product plus the bias. Partial sums outside [-1,1) do not wrap, so a final sum back inside the range is exact.
- R4: A lane whose index is not below in_lanes adds zero, whatever in_x holds on that lane.
- R5: Weight rows are written in order with wt_wr_en, starting from row 0 after reset. Each accepted pass reads the next row, and after the last row written it returns to row 0.
- R6: The final sum is multiplied by 2^in_scale, using the scale presented with the last pass. Values above SCALE_MAX are treated as SCALE_MAX.
- R7: The scaled result is saturated to [-2^L, 2^L-1] instead of wrapping.
- R8: out_valid is high for exactly one cycle per neuron, and never for a pass that is not the last. It rises right after the (PIPE+2)-th rising edge, counting the edge that samples the last pass as the first.
- R9: After reset, out_valid and out_sum are 0, no weight rows are loaded, and the next pass reads row 0.
- R10: A pass without in_first that arrives in ACC_IDLE is discarded and produces no output, even with in_last set. It still consumes a weight row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_wr_en | input | 1 | Append one weight row (one word per lane) |
| wt_wr_data | input | LANES*(N+1) | Weight row, lane i in bits [i*(N+1) +: N+1] |
| in_valid | input | 1 | A pass is presented this cycle |
| in_first | input | 1 | Pass is the first of a neuron (bias seeds the sum) |
| in_last | input | 1 | Pass is the last of a neuron (result emitted) |
| in_lanes | input | clog2(LANES+1) | Number of active lanes, counted from lane 0 |
| in_x | input | LANES*(N+1) | Input words, lane i in bits [i*(N+1) +: N+1] |
| in_bias | input | N+1 | Neuron bias, used on the first pass |
| in_scale | input | clog2(SCALE_MAX+1) | Left-shift amount applied to the final sum |
| out_valid | output | 1 | One-cycle strobe, result ready |
| out_sum | output | L+1 | Scaled, saturated weighted sum |

## Verification
The bench builds the block with four lanes, 8-bit words (N=7), an 11-bit product (L=10), eight weight rows, a scale of up to 3 and two extra sum-pipeline registers. With the truncation shift at 4 bits, floor rounding of negative products and the (-1)*(-1) clamp are visible. With only eleven result bits, four near-full-scale products overflow the result width. This lets a two-pass neuron whose partial sums leave the range and return show that the accumulator does not wrap. It also drives both saturation limits, including the exact lower bound reached through a shift. Loading only three rows makes the ring return visible on the fourth pass. PIPE=2 gives a latency that differs from the default.

// File: rtl/nmac_pkg.sv
package nmac_pkg;
    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RUN  = 1'b1
    } acc_state_e;
endpackage

// File: rtl/nmac_lane.sv
module nmac_lane #(
    parameter int N      = 7,
    parameter int L      = 10,
    parameter int WDEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(WDEPTH)-1:0] wr_addr,
    input  logic [N:0]                wr_data,
    input  logic [$clog2(WDEPTH)-1:0] rd_addr,
    input  logic [N:0]                x,
    input  logic                      act,
    output logic [L:0]                prod
);
    localparam int WW = N + 1;
    localparam int PW = L + 1;
    localparam int FW = 2 * WW;
    localparam int SH = 2 * N - L;
    localparam logic signed [FW-1:0] MAXP = FW'((1 << L) - 1);

    logic [WW-1:0] mem [WDEPTH];
    logic signed [FW-1:0] full;
    logic signed [FW-1:0] shr;
    logic [PW-1:0] trunc;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        full = $signed(x) * $signed(mem[rd_addr]);
        shr  = full >>> SH;
        if (shr > MAXP) trunc = MAXP[PW-1:0];
        else            trunc = shr[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prod <= '0;
        else if (act) prod <= trunc;
        else          prod <= '0;
    end
endmodule

// File: rtl/nmac_sum_pipe.sv
module nmac_sum_pipe #(
    parameter int LANES = 4,
    parameter int PW    = 11,
    parameter int WW    = 8,
    parameter int SW    = 2,
    parameter int SUMW  = 14,
    parameter int PIPE  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*PW-1:0]    prod,
    input  logic                   a_valid,
    input  logic                   a_first,
    input  logic                   a_last,
    input  logic [SW-1:0]          a_scale,
    input  logic [WW-1:0]          a_bias,
    output logic                   p_valid,
    output logic                   p_first,
    output logic                   p_last,
    output logic [SW-1:0]          p_scale,
    output logic [WW-1:0]          p_bias,
    output logic signed [SUMW-1:0] p_sum
);
    logic signed [SUMW-1:0] tree;

    always_comb begin
        tree = '0;
        for (int i = 0; i < LANES; i++) begin
            tree = tree + $signed({{(SUMW-PW){prod[i*PW+PW-1]}}, prod[i*PW +: PW]});
        end
    end

    generate
        if (PIPE == 0) begin : g_direct
            assign p_valid = a_valid;
            assign p_first = a_first;
            assign p_last  = a_last;
            assign p_scale = a_scale;
            assign p_bias  = a_bias;
            assign p_sum   = tree;
        end else begin : g_regs
            logic [PIPE-1:0]        v_q;
            logic [PIPE-1:0]        f_q;
            logic [PIPE-1:0]        l_q;
            logic [SW-1:0]          sc_q  [PIPE];
            logic [WW-1:0]          b_q   [PIPE];
            logic signed [SUMW-1:0] sum_q [PIPE];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= '0;
                    f_q <= '0;
                    l_q <= '0;
                    for (int i = 0; i < PIPE; i++) begin
                        sc_q[i]  <= '0;
                        b_q[i]   <= '0;
                        sum_q[i] <= '0;
                    end
                end else begin
                    v_q[0]   <= a_valid;
                    f_q[0]   <= a_first;
                    l_q[0]   <= a_last;
                    sc_q[0]  <= a_scale;
                    b_q[0]   <= a_bias;
                    sum_q[0] <= tree;
                    for (int i = 1; i < PIPE; i++) begin
                        v_q[i]   <= v_q[i-1];
                        f_q[i]   <= f_q[i-1];
                        l_q[i]   <= l_q[i-1];
                        sc_q[i]  <= sc_q[i-1];
                        b_q[i]   <= b_q[i-1];
                        sum_q[i] <= sum_q[i-1];
                    end
                end
            end

            assign p_valid = v_q[PIPE-1];
            assign p_first = f_q[PIPE-1];
            assign p_last  = l_q[PIPE-1];
            assign p_scale = sc_q[PIPE-1];
            assign p_bias  = b_q[PIPE-1];
            assign p_sum   = sum_q[PIPE-1];
        end
    endgenerate
endmodule

// File: rtl/nmac_accum.sv
module nmac_accum
    import nmac_pkg::*;
#(
    parameter int N         = 7,
    parameter int L         = 10,
    parameter int SW        = 2,
    parameter int SUMW      = 14,
    parameter int AW        = 17,
    parameter int SCALE_MAX = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   p_valid,
    input  logic                   p_first,
    input  logic                   p_last,
    input  logic [SW-1:0]          p_scale,
    input  logic [N:0]             p_bias,
    input  logic signed [SUMW-1:0] p_sum,
    output logic                   out_valid,
    output logic [L:0]             out_sum
);
    localparam int WW  = N + 1;
    localparam int PW  = L + 1;
    localparam int SHW = AW + SCALE_MAX;
    localparam logic signed [SHW-1:0] MAXO = SHW'((1 << L) - 1);
    localparam logic signed [SHW-1:0] MINO = ~MAXO;

    acc_state_e state_q, state_d;
    logic signed [AW-1:0]  acc_q;
    logic signed [AW-1:0]  bias_ext, sum_ext, base, total;
    logic signed [SHW-1:0] wide;
    logic [SW-1:0]         eff_scale;
    logic [PW-1:0]         clamped;
    logic                  take;

    assign take = p_valid && (p_first || state_q == ACC_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (p_valid && p_first && !p_last) state_d = ACC_RUN;
            ACC_RUN:  if (p_valid && p_last)             state_d = ACC_IDLE;
            default:                                     state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bias_ext  = $signed({{(AW-WW){p_bias[WW-1]}}, p_bias}) <<< (L - N);
        sum_ext   = $signed({{(AW-SUMW){p_sum[SUMW-1]}}, p_sum});
        base      = p_first ? bias_ext : acc_q;
        total     = base + sum_ext;
        eff_scale = (p_scale > SW'(SCALE_MAX)) ? SW'(SCALE_MAX) : p_scale;
        wide      = $signed({{SCALE_MAX{total[AW-1]}}, total}) <<< eff_scale;
        if (wide > MAXO)      clamped = MAXO[PW-1:0];
        else if (wide < MINO) clamped = MINO[PW-1:0];
        else                  clamped = wide[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= take && p_last;
            if (take) acc_q <= total;
            if (take && p_last) out_sum <= clamped;
        end
    end
endmodule

// File: rtl/neuron_mac_path.sv
module neuron_mac_path #(
    parameter int LANES     = 4,
    parameter int N         = 7,
    parameter int L         = 10,
    parameter int WDEPTH    = 8,
    parameter int SCALE_MAX = 3,
    parameter int PIPE      = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wt_wr_en,
    input  logic [LANES*(N+1)-1:0]           wt_wr_data,
    input  logic                             in_valid,
    input  logic                             in_first,
    input  logic                             in_last,
    input  logic [$clog2(LANES+1)-1:0]       in_lanes,
    input  logic [LANES*(N+1)-1:0]           in_x,
    input  logic [N:0]                       in_bias,
    input  logic [$clog2(SCALE_MAX+1)-1:0]   in_scale,
    output logic                             out_valid,
    output logic [L:0]                       out_sum
);
    localparam int WW   = N + 1;
    localparam int PW   = L + 1;
    localparam int LW   = $clog2(LANES + 1);
    localparam int SW   = $clog2(SCALE_MAX + 1);
    localparam int ADW  = $clog2(WDEPTH);
    localparam int FLW  = $clog2(WDEPTH + 1);
    localparam int SUMW = PW + $clog2(LANES + 1);
    localparam int AW   = PW + $clog2(LANES * WDEPTH + 2);

    logic [ADW-1:0] wr_ptr, rd_ptr;
    logic [FLW-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wt_wr_en) begin
            wr_ptr <= (wr_ptr == ADW'(WDEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (fill != FLW'(WDEPTH)) fill <= fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (in_valid && fill != '0) begin
            if (FLW'(rd_ptr) == fill - 1'b1) rd_ptr <= '0;
            else                             rd_ptr <= rd_ptr + 1'b1;
        end
    end

    logic              a_valid, a_first, a_last;
    logic [SW-1:0]     a_scale;
    logic [WW-1:0]     a_bias;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_first <= 1'b0;
            a_last  <= 1'b0;
            a_scale <= '0;
            a_bias  <= '0;
        end else begin
            a_valid <= in_valid;
            a_first <= in_first;
            a_last  <= in_last;
            a_scale <= in_scale;
            a_bias  <= in_bias;
        end
    end

    logic [LANES*PW-1:0] prod_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic act;
        assign act = in_valid && (LW'(i) < in_lanes);
        nmac_lane #(.N(N), .L(L), .WDEPTH(WDEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wt_wr_en),
            .wr_addr (wr_ptr),
            .wr_data (wt_wr_data[i*WW +: WW]),
            .rd_addr (rd_ptr),
            .x       (in_x[i*WW +: WW]),
            .act     (act),
            .prod    (prod_q[i*PW +: PW])
        );
    end

    logic                   p_valid, p_first, p_last;
    logic [SW-1:0]          p_scale;
    logic [WW-1:0]          p_bias;
    logic signed [SUMW-1:0] p_sum;

    nmac_sum_pipe #(
        .LANES(LANES), .PW(PW), .WW(WW), .SW(SW), .SUMW(SUMW), .PIPE(PIPE)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .prod    (prod_q),
        .a_valid (a_valid),
        .a_first (a_first),
        .a_last  (a_last),
        .a_scale (a_scale),
        .a_bias  (a_bias),
        .p_valid (p_valid),
        .p_first (p_first),
        .p_last  (p_last),
        .p_scale (p_scale),
        .p_bias  (p_bias),
        .p_sum   (p_sum)
    );

    nmac_accum #(
        .N(N), .L(L), .SW(SW), .SUMW(SUMW), .AW(AW), .SCALE_MAX(SCALE_MAX)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .p_valid   (p_valid),
        .p_first   (p_first),
        .p_last    (p_last),
        .p_scale   (p_scale),
        .p_bias    (p_bias),
        .p_sum     (p_sum),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );
endmodule

// File: rtl/nmac_checker.sv
module nmac_checker #(
    parameter int LANES  = 4,
    parameter int PW     = 11,
    parameter int ADW    = 3,
    parameter int FLW    = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [$clog2(LANES+1)-1:0] in_lanes,
    input logic [ADW-1:0]             rd_ptr,
    input logic [FLW-1:0]             fill,
    input logic [PW-1:0]              top_lane_prod,
    input logic                       p_valid,
    input logic                       p_last,
    input logic                       out_valid
);
    // R5: the read row always lies among the rows written so far
    a_r5_ptr_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |-> (FLW'(rd_ptr) < fill));

    // R5 and R9: with nothing loaded the read row stays at row 0
    a_r5_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> (rd_ptr == '0));

    // R4: the highest lane adds nothing when it is outside the active count
    a_r4_spare_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_lanes < ($clog2(LANES+1))'(LANES)) |=> (top_lane_prod == '0));

    // R8: a result only follows a last pass leaving the sum pipeline
    a_r8_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(p_valid && p_last));
endmodule

bind neuron_mac_path nmac_checker #(
    .LANES(LANES), .PW(PW), .ADW(ADW), .FLW(FLW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_lanes      (in_lanes),
    .rd_ptr        (rd_ptr),
    .fill          (fill),
    .top_lane_prod (prod_q[LANES*PW-1 -: PW]),
    .p_valid       (p_valid),
    .p_last        (p_last),
    .out_valid     (out_valid)
);

// File: tb/neuron_mac_path_test.sv
module neuron_mac_path_test;
    localparam int LANES = 4;
    localparam int N     = 7;
    localparam int L     = 10;
    localparam int WDEPTH = 8;
    localparam int SMAX  = 3;
    localparam int PIPE  = 2;
    localparam int WW    = N + 1;
    localparam int SH    = 2 * N - L;
    localparam int MAXO  = (1 << L) - 1;
    localparam int MINO  = -(1 << L);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wt_wr_en = 1'b0;
    logic [LANES*WW-1:0] wt_wr_data = '0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [2:0] in_lanes = '0;
    logic [LANES*WW-1:0] in_x = '0;
    logic [WW-1:0] in_bias = '0;
    logic [1:0] in_scale = '0;
    logic out_valid;
    logic [L:0] out_sum;

    int checks = 0;
    int errors = 0;
    int wref [WDEPTH][LANES];
    int xs [8][LANES];
    int fill_m = 0;
    int wp_m = 0;
    int rptr_m = 0;

    always #10 clk = ~clk;

    neuron_mac_path #(
        .LANES(LANES), .N(N), .L(L), .WDEPTH(WDEPTH), .SCALE_MAX(SMAX), .PIPE(PIPE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wt_wr_en(wt_wr_en), .wt_wr_data(wt_wr_data),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_lanes(in_lanes), .in_x(in_x), .in_bias(in_bias), .in_scale(in_scale),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_prod(input int x, input int w);
        int p;
        p = (x * w) >>> SH;
        if (p > MAXO) p = MAXO;
        return p;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        wt_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fill_m = 0;
        wp_m = 0;
        rptr_m = 0;
        @(negedge clk);
    endtask

    task automatic load_row(input int w0, input int w1, input int w2, input int w3);
        int w [LANES];
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        for (int l = 0; l < LANES; l++) begin
            wref[wp_m][l] = w[l];
            wt_wr_data[l*WW +: WW] = w[l][WW-1:0];
        end
        wt_wr_en = 1'b1;
        @(negedge clk);
        wt_wr_en = 1'b0;
        wp_m = (wp_m + 1) % WDEPTH;
        if (fill_m < WDEPTH) fill_m++;
    endtask

    task automatic load_seq(input int rows, input int seed);
        for (int r = 0; r < rows; r++)
            load_row(((r*37 + seed*11) % 255) - 127, ((r*53 + seed*7 + 40) % 255) - 127,
                     ((r*19 + seed*5 + 90) % 255) - 127, ((r*71 + seed*3 + 15) % 255) - 127);
    endtask

    task automatic fill_x(input int seed);
        for (int p = 0; p < 8; p++)
            for (int l = 0; l < LANES; l++)
                xs[p][l] = ((p*29 + l*41 + seed*13) % 31) - 15;
    endtask

    task automatic run_neuron(input int npass, input int lanes_last, input int bias,
                              input int scale, input string req);
        int acc, v, cnt, stray, nl;
        acc = bias <<< (L - N);
        stray = 0;
        for (int p = 0; p < npass; p++) begin
            nl = (p == npass - 1) ? lanes_last : LANES;
            for (int l = 0; l < nl; l++) acc += ref_prod(xs[p][l], wref[rptr_m][l]);
            rptr_m = (rptr_m + 1 == fill_m) ? 0 : rptr_m + 1;
            in_valid = 1'b1;
            in_first = (p == 0);
            in_last  = (p == npass - 1);
            in_lanes = 3'(nl);
            for (int l = 0; l < LANES; l++) in_x[l*WW +: WW] = xs[p][l][WW-1:0];
            in_bias  = bias[WW-1:0];
            in_scale = scale[1:0];
            @(negedge clk);
            if (out_valid) stray++;
        end
        in_valid = 1'b0;
        v = acc * (1 << scale);
        if (v > MAXO) v = MAXO;
        if (v < MINO) v = MINO;
        cnt = 1;
        while (!out_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk("R8 latency", cnt, PIPE + 2);
        chk("R8 no early strobe", stray, 0);
        chk(req, int'($signed(out_sum)), v);
        @(negedge clk);
        chk("R8 one-cycle strobe", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 out_valid after reset", int'(out_valid), 0);
        chk("R9 out_sum after reset", int'(out_sum), 0);
    endtask

    task automatic t_single();
        do_reset();
        load_seq(8, 1);
        fill_x(2);
        run_neuron(1, 4, 20, 0, "R2 single pass with bias");
        fill_x(5);
        run_neuron(1, 4, -37, 0, "R2 negative bias");
    endtask

    task automatic t_multi();
        do_reset();
        load_seq(8, 3);
        fill_x(7);
        xs[2][2] = 77; xs[2][3] = -90;
        run_neuron(3, 2, 11, 1, "R2 R4 three passes, partial last");
        fill_x(9);
        xs[1][1] = 60; xs[1][2] = 61; xs[1][3] = 62;
        run_neuron(2, 1, -5, 0, "R4 one active lane on last pass");
    endtask

    task automatic t_wide();
        do_reset();
        load_row(120, 120, 120, 120);
        load_row(-120, -120, -120, -120);
        for (int l = 0; l < LANES; l++) begin xs[0][l] = 127; xs[1][l] = 127; end
        run_neuron(2, 4, 8, 0, "R3 partial sum beyond range returns");
    endtask

    task automatic t_scale_sat();
        do_reset();
        load_row(120, 120, 120, 120);
        load_row(-120, -120, -120, -120);
        run_neuron(1, 0, 30, 2, "R6 bias only scaled by 4");
        run_neuron(1, 0, -16, 3, "R6 R7 exact lower bound via shift");
        for (int l = 0; l < LANES; l++) xs[0][l] = 127;
        run_neuron(1, 4, 0, 0, "R7 positive saturation");
        run_neuron(1, 4, 0, 0, "R7 negative saturation");
    endtask

    task automatic t_clamp();
        do_reset();
        load_row(-128, 1, 1, 0);
        xs[0][0] = -128; xs[0][1] = -128; xs[0][2] = -1; xs[0][3] = 5;
        run_neuron(1, 3, 0, 0, "R1 clamp of -1*-1 and floor truncation");
    endtask

    task automatic t_wrap();
        do_reset();
        load_seq(3, 6);
        for (int k = 0; k < 5; k++) begin
            fill_x(k + 20);
            run_neuron(1, 4, k * 3, 0, "R5 ring of three rows");
        end
    endtask

    task automatic t_orphan();
        int seen;
        do_reset();
        load_seq(4, 8);
        fill_x(30);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_lanes = 3'd4;
        in_bias = 8'd50; in_scale = 2'd0;
        @(negedge clk);
        in_valid = 1'b0;
        rptr_m = (rptr_m + 1 == fill_m) ? 0 : rptr_m + 1;
        seen = 0;
        repeat (PIPE + 4) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk("R10 orphan pass gives no result", seen, 0);
        run_neuron(1, 4, 9, 0, "R10 R5 next neuron uses following row");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_wide();
        t_scale_sat();
        t_clamp();
        t_wrap();
        t_orphan();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule